// File: doc/BRIEF.md
# Oscillator Tuning Register Write Port

This block is the host-facing register file that sets up a numerically controlled oscillator. A host drives an 8-bit data bus, a 4-bit address, an active-low select and a write strobe. Together these load three buffers: two 32-bit frequency increments, called bank A and bank B, and one 12-bit phase offset. All three buffers are presented in full on the outputs, where the oscillator core picks them up.

The block samples the write strobe in the system clock domain. A write takes effect at the first clock edge at which the strobe is seen high after it was seen low. The frequency banks are written one byte lane at a time. The phase offset is written in two parts: a low nibble, taken from the upper half of the data bus, and a high byte. The host may write bytes in any order and need only rewrite the bytes that change.

Top module: `nco_tuning_regs`

## Requirements
- R1: While `cs_n` is 1 at the strobe's sampled rising edge, no buffer changes.
- R2: Each low-to-high transition of `wr_strobe` writes at most once. Holding the strobe high, or changing `addr`/`data` while it stays high, writes nothing further.
- R3: With `addr[3]`=0, `addr[2]`=0 selects bank A and `addr[2]`=1 selects bank B. `addr[1:0]`=n writes `data` into bits 8n+7..8n of the selected bank.
- R4: With `addr[3]`=1, `addr[1]`=0 and `addr[0]`=0, `data[7:4]` is written into phase bits 3..0. Phase bits 11..4 keep their value. `addr[2]` has no effect.
- R5: With `addr[3]`=1, `addr[1]`=0 and `addr[0]`=1, `data[7:0]` is written into phase bits 11..4. Phase bits 3..0 keep their value.
- R6: With `addr[3]`=1 and `addr[1]`=1, the write changes no buffer.
- R7: Every write changes only the addressed bits. Writes may arrive in any order, and bytes that are not written keep their values.
- R8: While `rst_n` is 0, all three buffers read zero.
- R9: A qualified write is visible on the outputs right after the first rising `clk` edge at which `wr_strobe` is sampled 1, following a sample of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Select, active low |
| wr_strobe | input | 1 | Write strobe, rising edge writes |
| addr | input | 4 | Register and lane address |
| data | input | 8 | Write data |
| freq_a | output | 32 | Frequency increment bank A |
| freq_b | output | 32 | Frequency increment bank B |
| phase_ofs | output | 12 | Phase offset buffer |

## Verification
The hardest case to reach is a strobe held high across several clocks while the address and data change underneath it. Only the values present at the first sampled high may land. The driver can stretch a strobe for a chosen number of cycles and replace the data after its first cycle, so any second write would show up as the replacement value. The writes are also ordered so that partial phase nibble and byte writes overlap earlier full values. This exposes any bit that the block overwrites but should have kept.

// File: rtl/nco_tuning_regs.sv
module nco_tuning_regs #(
  parameter int DW = 8,
  parameter int FW = 32,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_strobe,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] data,
  output logic [FW-1:0] freq_a,
  output logic [FW-1:0] freq_b,
  output logic [PW-1:0] phase_ofs
);
  localparam int LANES = FW / DW;
  localparam int LW    = $clog2(LANES);
  localparam int NIB   = DW / 2;

  logic strb_q;
  logic wr_en;
  logic [LW-1:0] lane;

  assign wr_en = wr_strobe & ~strb_q & ~cs_n;
  assign lane  = addr[LW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= wr_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_a    <= '0;
      freq_b    <= '0;
      phase_ofs <= '0;
    end else if (wr_en) begin
      if (!addr[3]) begin
        if (addr[2]) freq_b[lane*DW +: DW] <= data;
        else         freq_a[lane*DW +: DW] <= data;
      end else if (!addr[1]) begin
        if (addr[0]) phase_ofs[PW-1:NIB] <= data;
        else         phase_ofs[NIB-1:0]  <= data[DW-1:NIB];
      end
    end
  end

  assert_cs_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(freq_a) && $stable(freq_b) && $stable(phase_ofs)));

  assert_no_edge_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_strobe || strb_q) |=> ($stable(freq_a) && $stable(freq_b) && $stable(phase_ofs)));

  assert_bank_a_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !strb_q && !cs_n && addr[3:2] == 2'b00)
      |=> (freq_a[$past(lane)*DW +: DW] == $past(data) && $stable(freq_b) && $stable(phase_ofs)));

  assert_bank_b_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !strb_q && !cs_n && addr[3:2] == 2'b01)
      |=> (freq_b[$past(lane)*DW +: DW] == $past(data) && $stable(freq_a) && $stable(phase_ofs)));

  assert_phase_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !strb_q && !cs_n && addr[3] && addr[1:0] == 2'b00)
      |=> (phase_ofs[NIB-1:0] == $past(data[DW-1:NIB]) && $stable(phase_ofs[PW-1:NIB])));

  assert_phase_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !strb_q && !cs_n && addr[3] && addr[1:0] == 2'b01)
      |=> (phase_ofs[PW-1:NIB] == $past(data) && $stable(phase_ofs[NIB-1:0])));

  assert_phase_hole_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[3] && addr[1]) |=> ($stable(freq_a) && $stable(freq_b) && $stable(phase_ofs)));
endmodule

// File: tb/tb_nco_tuning_regs.sv
module tb_nco_tuning_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] fa;
    logic [31:0] fb;
    logic [11:0] ph;
  } snap_t;

  logic clk = 0, rst_n = 0, cs_n = 1, wr_strobe = 0;
  logic [3:0] addr = 0;
  logic [7:0] data = 0;
  logic [31:0] freq_a, freq_b;
  logic [11:0] phase_ofs;

  int checks = 0, fails = 0;
  snap_t model = '0;
  snap_t exp_q[$];
  string tag_q[$];
  event chk;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_tuning_regs dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_strobe(wr_strobe),
    .addr(addr), .data(data), .freq_a(freq_a), .freq_b(freq_b), .phase_ofs(phase_ofs));

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial forever begin
    @(chk);
    while (exp_q.size() > 0) begin
      snap_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "freq_a", freq_a, e.fa);
      cmp(t, "freq_b", freq_b, e.fb);
      cmp(t, "phase_ofs", {20'd0, phase_ofs}, {20'd0, e.ph});
    end
  end

  task automatic push(string tag);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    ->chk;
    #0;
  endtask

  function automatic void apply(logic sel_n, logic [3:0] a, logic [7:0] d);
    if (sel_n) return;
    if (!a[3]) begin
      if (a[2]) model.fb[a[1:0]*8 +: 8] = d;
      else      model.fa[a[1:0]*8 +: 8] = d;
    end else if (!a[1]) begin
      if (a[0]) model.ph[11:4] = d;
      else      model.ph[3:0]  = d[7:4];
    end
  endfunction

  task automatic wr(string tag, logic sel_n, logic [3:0] a, logic [7:0] d,
                    int hold = 1, logic [7:0] alt = 8'h00, logic use_alt = 0);
    @(negedge clk);
    cs_n = sel_n; addr = a; data = d; wr_strobe = 1;
    apply(sel_n, a, d);
    @(negedge clk);
    push("R9");
    for (int i = 1; i < hold; i++) begin
      if (use_alt) begin data = alt; addr = a ^ 4'b0001; end
      @(negedge clk);
    end
    wr_strobe = 0; cs_n = 1;
    @(negedge clk);
    push(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    push("R8");
    rst_n = 1;
    wr("R3", 0, 4'b0000, 8'h11);
    wr("R3", 0, 4'b0011, 8'h44);
    wr("R3", 0, 4'b0101, 8'hB2);
    wr("R3", 0, 4'b0110, 8'hB3);
    wr("R7", 0, 4'b0010, 8'h33);
    wr("R7", 0, 4'b0001, 8'h22);
    wr("R7", 0, 4'b0000, 8'hA5);
    wr("R1", 1, 4'b0001, 8'hEE);
    wr("R1", 1, 4'b1001, 8'hEE);
    wr("R5", 0, 4'b1001, 8'hC3);
    wr("R4", 0, 4'b1100, 8'h9F);
    wr("R4", 0, 4'b1000, 8'h5A);
    wr("R5", 0, 4'b1101, 8'h7E);
    wr("R6", 0, 4'b1010, 8'hFF);
    wr("R6", 0, 4'b1111, 8'hFF);
    wr("R2", 0, 4'b0100, 8'h01, 4, 8'hDD, 1);
    wr("R2", 0, 4'b1001, 8'h42, 3, 8'h99, 1);
    @(negedge clk);
    rst_n = 0;
    model = '0;
    @(negedge clk);
    push("R8");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule